// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block is one copy channel that moves data between locations of a single memory. Work is described by two circular descriptor rings in that memory. The host fills source descriptors, each naming a buffer, a byte count and flags. It also posts empty destination buffers. For each ring it programs a base address, an entry count and a producer (write) index through a small register port. The engine consumes source descriptors up to the source write index and copies the referenced bytes, one 32-bit word at a time, into the buffer named by the oldest posted destination descriptor. It then writes the delivered byte count and the metadata back into that destination descriptor.

Source descriptors marked as gather pieces are chained. All pieces of a chain land back to back in one destination buffer, and the chain produces a single completion. A nonzero count in a destination descriptor is the host's only sign that the descriptor is finished. A separate interrupt block consumes the one-cycle completion pulse. The engine reads and writes memory over a fixed-latency bus: read data is returned in the cycle after the request.

Descriptor layout (8 bytes, little-endian words): word 0 is the 32-bit buffer address. Word 1 holds the byte count in bits [15:0] and flags in bits [31:16]. In the flags, bit 16 is gather, bit 17 is byte swap and bits [31:18] are a 14-bit metadata tag. Register word addresses: 0 source base, 1 source entry count, 2 source write index, 3 source read index (read only), 4 destination base, 5 destination entry count, 6 destination write index, 7 destination read index (read only), 8 maximum length in bytes, 9 status (bit 0 truncation error, write 1 to clear), 10 free slots (source in [15:0], destination in [31:16]). All other addresses read as zero.

Top module: `dring_copy_engine`

## Requirements
- R1: For every source descriptor with count N, the engine reads ceil(N/4) consecutive words from the source buffer and writes them to consecutive words of the destination buffer. No word is written beyond them.
- R2: Entry counts are powers of two. A written write index is masked with (entries-1), and each read index advances by one and wraps to 0 after entries-1.
- R3: The free-slot field of each ring reads (read_index - write_index - 1) & (entries-1), so a ring of E entries shows at most E-1 free slots and shows 0 when E-1 descriptors are outstanding.
- R4: The engine never consumes a source descriptor at or beyond the source write index. Descriptors written to memory without a write-index update stay untouched.
- R5: A chain of source descriptors whose gather flag (bit 16) is set, closed by one with it clear, fills one destination buffer back to back and yields exactly one completion pulse.
- R6: On completion, word 1 of the destination descriptor becomes {metadata of the closing piece in [31:18], its swap flag in bit 17, 0 in bit 16, total byte count in [15:0]}, and the count is nonzero.
- R7: The source read index rises by one per consumed source descriptor. The destination read index rises by one per completion, in the same cycle as the pulse.
- R8: With the swap flag (bit 17) set, each copied word has its four bytes reversed; with it clear, the word is copied unchanged.
- R9: With no posted destination buffer, the engine waits without consuming source work and resumes once a buffer is posted, losing no data.
- R10: A word that would take the delivered count past the maximum length is not written. The rest of that descriptor is skipped, and status bit 0 and the trunc_err output are set until a 1 is written to status bit 0.
- R11: After reset both read indices, both write indices and the status are zero, and no completion is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| cmpl_pulse | output | 1 | One-cycle completion event per destination buffer |
| trunc_err | output | 1 | Sticky truncation error |

## Verification
On every cycle, the assertions check that the source read index moves only while work is visible below the write index. They check that the destination index moves only with a completion pulse, that completions never come back to back, and that every written completion count is nonzero and within the maximum length. The exact data placement, byte reversal, gather concatenation, descriptor write-back values, ring wrap, free-slot arithmetic, stalling on an empty destination ring and the truncation cut-off are shown only by the bench. It compares memory contents and register reads against its own model, using directed corner cases and random chains.

// File: rtl/dring_pkg.sv
package dring_pkg;
   localparam int LEN_W      = 16;
   localparam int FLG_GATHER = 0;
   localparam int FLG_SWAP   = 1;
   localparam int META_LSB   = 2;
   localparam int META_W     = 14;

   localparam logic [3:0] RA_SRC_BASE = 4'd0;
   localparam logic [3:0] RA_SRC_SIZE = 4'd1;
   localparam logic [3:0] RA_SRC_WIDX = 4'd2;
   localparam logic [3:0] RA_SRC_RIDX = 4'd3;
   localparam logic [3:0] RA_DST_BASE = 4'd4;
   localparam logic [3:0] RA_DST_SIZE = 4'd5;
   localparam logic [3:0] RA_DST_WIDX = 4'd6;
   localparam logic [3:0] RA_DST_RIDX = 4'd7;
   localparam logic [3:0] RA_MAXLEN   = 4'd8;
   localparam logic [3:0] RA_STATUS   = 4'd9;
   localparam logic [3:0] RA_FREE     = 4'd10;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SRC0, ST_SRC1, ST_DST0, ST_CPRD, ST_CPWR, ST_NEXT, ST_FIN
   } eng_state_e;
endpackage

// File: rtl/dring_index.sv
module dring_index #(
   parameter int IDX_W  = 8,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic              size_we,
   input  logic              widx_we,
   input  logic [31:0]       wdata,
   input  logic              adv,
   output logic [IDX_W-1:0]  widx,
   output logic [IDX_W-1:0]  ridx,
   output logic [IDX_W-1:0]  free_cnt,
   output logic              avail,
   output logic [ADDR_W-1:0] slot_addr
);
   localparam int DESC_SHIFT = 3;

   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         widx   <= '0;
         ridx   <= '0;
      end else begin
         if (base_we) base_q <= wdata[ADDR_W-1:0];
         if (size_we) mask_q <= wdata[IDX_W-1:0] - 1'b1;
         if (widx_we) widx   <= wdata[IDX_W-1:0] & mask_q;
         if (adv)     ridx   <= (ridx + 1'b1) & mask_q;
      end
   end

   assign avail     = (ridx != widx);
   assign free_cnt  = (ridx - widx - 1'b1) & mask_q;
   assign slot_addr = base_q + (ADDR_W'(ridx) << DESC_SHIFT);
endmodule

// File: rtl/dring_lane_swap.sv
module dring_lane_swap #(
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic        en,
   input  logic [31:0] din,
   output logic [31:0] dout
);
   generate
      if (SWAP_SUPPORT) begin : g_swap
         assign dout = en ? {din[7:0], din[15:8], din[23:16], din[31:24]} : din;
      end else begin : g_pass
         assign dout = en ? din : din;
      end
   endgenerate
endmodule

// File: rtl/dring_copy_engine.sv
module dring_copy_engine
   import dring_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          IDX_W        = 8,
   parameter bit          SWAP_SUPPORT = 1'b1,
   parameter logic [15:0] DEF_MAX_LEN  = 16'd256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              cmpl_pulse,
   output logic              trunc_err
);
   localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("IDX_W must lie in 1..16");
      end
      if (ADDR_W != 32) begin : g_bad_addr
         $error("ADDR_W must be 32");
      end
   endgenerate

   eng_state_e        state_q;
   logic [ADDR_W-1:0] sbuf_q, dbuf_q;
   logic [LEN_W-1:0]  rem_q, soff_q, total_q, maxlen_q, take;
   logic [META_W-1:0] meta_q;
   logic              swap_q, gth_q, in_list_q, cmpl_q, err_q;
   logic              over, start, cpl_wr;
   logic [31:0]       swapped;

   logic [IDX_W-1:0]  src_widx, src_ridx, src_free, dst_widx, dst_ridx, dst_free;
   logic              src_avail, dst_avail;
   logic [ADDR_W-1:0] src_slot, dst_slot;

   dring_index #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_src_ring (
      .clk(clk), .rst_n(rst_n),
      .base_we(reg_we && reg_addr == RA_SRC_BASE),
      .size_we(reg_we && reg_addr == RA_SRC_SIZE),
      .widx_we(reg_we && reg_addr == RA_SRC_WIDX),
      .wdata(reg_wdata), .adv(state_q == ST_NEXT),
      .widx(src_widx), .ridx(src_ridx), .free_cnt(src_free),
      .avail(src_avail), .slot_addr(src_slot)
   );

   dring_index #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dst_ring (
      .clk(clk), .rst_n(rst_n),
      .base_we(reg_we && reg_addr == RA_DST_BASE),
      .size_we(reg_we && reg_addr == RA_DST_SIZE),
      .widx_we(reg_we && reg_addr == RA_DST_WIDX),
      .wdata(reg_wdata), .adv(state_q == ST_FIN),
      .widx(dst_widx), .ridx(dst_ridx), .free_cnt(dst_free),
      .avail(dst_avail), .slot_addr(dst_slot)
   );

   dring_lane_swap #(.SWAP_SUPPORT(SWAP_SUPPORT)) u_swap (
      .en(swap_q), .din(mem_rdata), .dout(swapped)
   );

   assign take   = (rem_q > WORD_BYTES) ? WORD_BYTES : rem_q;
   assign over   = ({1'b0, total_q} + {1'b0, take}) > {1'b0, maxlen_q};
   assign start  = src_avail && (in_list_q || dst_avail);
   assign cpl_wr = (state_q == ST_NEXT) && !gth_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         sbuf_q    <= '0;
         dbuf_q    <= '0;
         rem_q     <= '0;
         soff_q    <= '0;
         total_q   <= '0;
         meta_q    <= '0;
         swap_q    <= 1'b0;
         gth_q     <= 1'b0;
         in_list_q <= 1'b0;
         cmpl_q    <= 1'b0;
         err_q     <= 1'b0;
         maxlen_q  <= DEF_MAX_LEN;
      end else begin
         cmpl_q <= 1'b0;
         if (reg_we && reg_addr == RA_MAXLEN) maxlen_q <= reg_wdata[LEN_W-1:0];
         if (reg_we && reg_addr == RA_STATUS && reg_wdata[0]) err_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) state_q <= ST_SRC0;
            ST_SRC0: begin
               sbuf_q  <= mem_rdata[ADDR_W-1:0];
               soff_q  <= '0;
               state_q <= ST_SRC1;
            end
            ST_SRC1: begin
               rem_q   <= mem_rdata[LEN_W-1:0];
               gth_q   <= mem_rdata[LEN_W+FLG_GATHER];
               swap_q  <= mem_rdata[LEN_W+FLG_SWAP];
               meta_q  <= mem_rdata[LEN_W+META_LSB +: META_W];
               state_q <= in_list_q ? ST_CPRD : ST_DST0;
            end
            ST_DST0: begin
               dbuf_q  <= mem_rdata[ADDR_W-1:0];
               total_q <= '0;
               state_q <= ST_CPRD;
            end
            ST_CPRD: begin
               if (rem_q == '0) begin
                  state_q <= ST_NEXT;
               end else if (over) begin
                  err_q   <= 1'b1;
                  rem_q   <= '0;
                  state_q <= ST_NEXT;
               end else begin
                  state_q <= ST_CPWR;
               end
            end
            ST_CPWR: begin
               total_q <= total_q + take;
               rem_q   <= rem_q - take;
               soff_q  <= soff_q + WORD_BYTES;
               state_q <= ST_CPRD;
            end
            ST_NEXT: begin
               if (gth_q) begin
                  in_list_q <= 1'b1;
                  state_q   <= ST_IDLE;
               end else begin
                  state_q   <= ST_FIN;
               end
            end
            ST_FIN: begin
               in_list_q <= 1'b0;
               cmpl_q    <= 1'b1;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state_q)
         ST_IDLE: if (start) begin
            mem_req  = 1'b1;
            mem_addr = src_slot;
         end
         ST_SRC0: begin
            mem_req  = 1'b1;
            mem_addr = src_slot + ADDR_W'(4);
         end
         ST_SRC1: if (!in_list_q) begin
            mem_req  = 1'b1;
            mem_addr = dst_slot;
         end
         ST_CPRD: if (rem_q != '0 && !over) begin
            mem_req  = 1'b1;
            mem_addr = sbuf_q + ADDR_W'(soff_q);
         end
         ST_CPWR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dbuf_q + ADDR_W'(total_q);
            mem_wdata = swapped;
         end
         ST_NEXT: if (cpl_wr) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dst_slot + ADDR_W'(4);
            mem_wdata = {meta_q, swap_q, 1'b0, total_q};
         end
         default: ;
      endcase
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_SRC_WIDX: reg_rdata = 32'(src_widx);
         RA_SRC_RIDX: reg_rdata = 32'(src_ridx);
         RA_DST_WIDX: reg_rdata = 32'(dst_widx);
         RA_DST_RIDX: reg_rdata = 32'(dst_ridx);
         RA_MAXLEN:   reg_rdata = 32'(maxlen_q);
         RA_STATUS:   reg_rdata = 32'(err_q);
         RA_FREE:     reg_rdata = {16'(dst_free), 16'(src_free)};
         default:     reg_rdata = '0;
      endcase
   end

   assign cmpl_pulse = cmpl_q;
   assign trunc_err  = err_q;
endmodule

// File: rtl/dring_copy_engine_chk.sv
module dring_copy_engine_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req,
   input logic             mem_we,
   input logic             cmpl_pulse,
   input logic [IDX_W-1:0] src_ridx,
   input logic [IDX_W-1:0] dst_ridx,
   input logic             src_avail,
   input logic             cpl_wr,
   input logic [15:0]      cpl_count,
   input logic [15:0]      max_len
);
   // R1: a write is always part of a request
   assert_we_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

   // R4: the source read index only moves while work is visible
   assert_src_within_widx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ridx != $past(src_ridx)) |-> $past(src_avail));

   // R5 / R7: destination index moves only together with a completion
   assert_dst_adv_with_cmpl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_ridx != $past(dst_ridx)) |-> cmpl_pulse);

   // R5: completions are single-cycle events
   assert_cmpl_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_pulse |=> !cmpl_pulse);

   // R6: a written completion count is never zero
   assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_wr |-> (cpl_count != 16'd0));

   // R10: a written completion count respects the length limit
   assert_count_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_wr |-> (cpl_count <= max_len));
endmodule

bind dring_copy_engine dring_copy_engine_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .cmpl_pulse(cmpl_pulse), .src_ridx(src_ridx), .dst_ridx(dst_ridx),
   .src_avail(src_avail), .cpl_wr(cpl_wr), .cpl_count(total_q),
   .max_len(maxlen_q)
);

// File: tb/dring_copy_engine_bench.sv
module dring_copy_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        cmpl_pulse, trunc_err;

   always #10 clk = ~clk;

   dring_copy_engine u_dring_copy_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .cmpl_pulse(cmpl_pulse), .trunc_err(trunc_err)
   );

   localparam int SRC_RING = 32'h0000;
   localparam int DST_RING = 32'h0100;
   localparam int SRC_BUF  = 32'h1000;
   localparam int DST_BUF  = 32'h2000;
   localparam logic [31:0] SENT = 32'hDEAD_BEEF;

   logic [31:0] mem [4096];
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
         mem_rdata <= mem[mem_addr[13:2]];
      end
   end

   int n_run = 0, n_fail = 0, cmpl_cnt = 0;
   bit done = 1'b0;
   always @(posedge clk) if (rst_n && cmpl_pulse) cmpl_cnt <= cmpl_cnt + 1;

   int s_w = 0, d_w = 0, maxlen_b = 256;
   logic [31:0] ex_data [8][64];
   int          ex_nw [8];
   int          ex_tot [8];
   logic [31:0] ex_w1 [8];
   bit          ex_err = 1'b0;

   function automatic logic [31:0] rev(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_dst();
      mem[(DST_RING + d_w*8) >> 2]     = DST_BUF + d_w*256;
      mem[(DST_RING + d_w*8 + 4) >> 2] = 32'h0;
      for (int i = 0; i < 64; i++) mem[(DST_BUF + d_w*256) / 4 + i] = SENT;
      ex_nw[d_w] = 0; ex_tot[d_w] = 0;
      d_w = (d_w + 1) & 7;
   endtask

   task automatic put_src(input int ds, input int len, input bit sw, input bit gth, input int meta);
      int rem, tk;
      logic [31:0] w;
      mem[(SRC_RING + s_w*8) >> 2]     = SRC_BUF + s_w*128;
      mem[(SRC_RING + s_w*8 + 4) >> 2] = {meta[13:0], sw, gth, len[15:0]};
      rem = len;
      for (int i = 0; i < (len + 3) / 4; i++) begin
         w = $urandom;
         mem[(SRC_BUF + s_w*128) / 4 + i] = w;
         tk = (rem > 4) ? 4 : rem;
         if (rem > 0) begin
            if (ex_tot[ds] + tk > maxlen_b) begin
               ex_err = 1'b1;
               rem = 0;
            end else begin
               ex_data[ds][ex_nw[ds]] = sw ? rev(w) : w;
               ex_nw[ds]++;
               ex_tot[ds] += tk;
               rem -= tk;
            end
         end
      end
      ex_w1[ds] = {meta[13:0], sw, 1'b0, ex_tot[ds][15:0]};
      s_w = (s_w + 1) & 7;
   endtask

   task automatic wait_cmpl(input int target);
      int t = 0;
      while (cmpl_cnt < target && t < 3000) begin
         @(negedge clk); t++;
      end
      repeat (2) @(negedge clk);
      check("R5 completion count", cmpl_cnt, target);
   endtask

   task automatic verify_dst(input int ds, input string req);
      check("R6 descriptor word", mem[(DST_RING + ds*8 + 4) >> 2], ex_w1[ds]);
      for (int i = 0; i < ex_nw[ds]; i++)
         check(req, mem[(DST_BUF + ds*256) / 4 + i], ex_data[ds][i]);
      check("R1 no extra word", mem[(DST_BUF + ds*256) / 4 + ex_nw[ds]], SENT);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int base_c, ds, np, ln, sw, meta;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      #1;
      check("R11 cmpl after reset", 32'(cmpl_pulse), 0);
      rst_n = 1'b1;
      rd(4'd3, v); check("R11 src ridx reset", v, 0);
      rd(4'd7, v); check("R11 dst ridx reset", v, 0);
      rd(4'd2, v); check("R11 src widx reset", v, 0);
      rd(4'd9, v); check("R11 status reset", v, 0);

      wr(4'd0, SRC_RING); wr(4'd1, 8);
      wr(4'd4, DST_RING); wr(4'd5, 8);
      wr(4'd8, 256);
      rd(4'd10, v); check("R3 free empty rings", v, {16'd7, 16'd7});

      // stall on empty destination ring with a full source ring
      for (int i = 0; i < 7; i++) put_src(i, 8, 1'b0, 1'b0, 100 + i);
      for (int i = 0; i < 7; i++) begin
         ex_nw[i] = 0; ex_tot[i] = 0;
      end
      s_w = 0;
      for (int i = 0; i < 7; i++) put_src(i, 8, 1'b0, 1'b0, 100 + i);
      wr(4'd2, s_w);
      rd(4'd10, v); check("R3 free full source ring", v[15:0], 0);
      repeat (40) @(negedge clk);
      rd(4'd3, v); check("R9 no source consumed while stalled", v, 0);
      check("R9 no completion while stalled", cmpl_cnt, 0);
      for (int i = 0; i < 7; i++) begin
         mem[(DST_RING + i*8) >> 2]     = DST_BUF + i*256;
         mem[(DST_RING + i*8 + 4) >> 2] = 32'h0;
         for (int j = 0; j < 64; j++) mem[(DST_BUF + i*256) / 4 + j] = SENT;
      end
      d_w = 7;
      wr(4'd6, d_w);
      wait_cmpl(7);
      for (int i = 0; i < 7; i++) verify_dst(i, "R9 data after resume");
      rd(4'd3, v); check("R7 src ridx after seven", v, 7);
      rd(4'd7, v); check("R7 dst ridx after seven", v, 7);

      // gather chain held back by the write index
      ds = d_w; put_dst(); wr(4'd6, d_w);
      base_c = cmpl_cnt;
      put_src(ds, 8, 1'b1, 1'b1, 9);
      put_src(ds, 12, 1'b1, 1'b1, 9);
      put_src(ds, 6, 1'b1, 1'b0, 77);
      repeat (30) @(negedge clk);
      rd(4'd3, v); check("R4 unpublished chain untouched", v, 7);
      check("R4 no completion before publish", cmpl_cnt, base_c);
      wr(4'd2, s_w);
      wait_cmpl(base_c + 1);
      verify_dst(ds, "R5 R8 gathered swapped data");
      check("R5 gathered count", ex_w1[ds][15:0], 26);
      rd(4'd3, v); check("R2 src ridx wrapped", v, s_w);

      // truncation against the length limit
      wr(4'd8, 16); maxlen_b = 16;
      ds = d_w; put_dst(); wr(4'd6, d_w);
      base_c = cmpl_cnt;
      put_src(ds, 24, 1'b0, 1'b0, 5);
      wr(4'd2, s_w);
      wait_cmpl(base_c + 1);
      verify_dst(ds, "R10 truncated data");
      check("R10 truncated count", mem[(DST_RING + ds*8 + 4) >> 2] & 32'hFFFF, 16);
      rd(4'd9, v); check("R10 status set", v, 1);
      check("R10 trunc_err pin", 32'(trunc_err), 1);
      wr(4'd9, 1);
      rd(4'd9, v); check("R10 status cleared", v, 0);
      wr(4'd8, 256); maxlen_b = 256;

      // random chains
      for (int k = 0; k < 24; k++) begin
         ds = d_w; put_dst(); wr(4'd6, d_w);
         base_c = cmpl_cnt;
         np = 1 + ($urandom % 3);
         sw = $urandom % 2;
         meta = $urandom % 16384;
         for (int p = 0; p < np; p++) begin
            ln = (p == np - 1) ? 1 + ($urandom % 32) : 4 * (1 + ($urandom % 8));
            put_src(ds, ln, sw[0], p != np - 1, meta);
         end
         wr(4'd2, s_w);
         wait_cmpl(base_c + 1);
         verify_dst(ds, sw ? "R8 swapped random data" : "R1 random data");
         rd(4'd3, v); check("R2 R7 src ridx random", v, s_w);
         rd(4'd7, v); check("R2 R7 dst ridx random", v, d_w);
      end
      rd(4'd10, v); check("R3 free after drain", v, {16'd7, 16'd7});
      rd(4'd9, v); check("R10 no spurious error", v, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule